// File: doc/BRIEF.md
# Condition-Flag Register and Branch Resolver

This block keeps the sign state of the last value written to the register file of a 16-bit accumulator-style processor. The state is three one-hot flags: negative, zero and strictly positive. A register-write strobe with its data updates the flags on the next clock edge. When no write occurs, the flags keep their value. Reset loads the zero flag, so a conditional branch has a defined outcome before any register has been written.

A second, combinational path examines the current instruction word. If the word carries the branch opcode, a three-bit condition mask in the word is compared against the flags. The branch is taken when any selected flag is set. An empty mask makes the instruction a no-op, and a full mask makes it unconditional. The branch target is the incremented program counter plus the sign-extended 9-bit offset field, wrapping at 16 bits.

Top module: `ccr_branch_unit`

## Requirements
- R1: After reset, and before any register write, the flags output is 3'b010 (bit 2 negative, bit 1 zero, bit 0 positive).
- R2: Exactly one bit of the flags output is set in every cycle after reset.
- R3: A write whose data has bit 15 set makes the flags 3'b100 from the clock edge that samples the write onward.
- R4: A write of 16'h0000 makes the flags 3'b010 from the sampling edge onward.
- R5: A write of a nonzero value with bit 15 clear makes the flags 3'b001 from the sampling edge onward.
- R6: In a cycle with the write strobe low, the flags do not change.
- R7: When instr[15:12] is 4'b0000, br_taken equals (instr[11] & N) | (instr[10] & Z) | (instr[9] & P) using the current flags, in the same cycle.
- R8: A branch with instr[11:9] = 3'b000 (for example the word 16'h0000) is never taken, whatever the flags.
- R9: A branch with instr[11:9] = 3'b111 (for example the word 16'h0E00) is always taken.
- R10: When instr[15:12] is not 4'b0000, br_taken is 0.
- R11: br_target equals pc_next plus instr[8:0] sign-extended to 16 bits, modulo 2^16, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Register-write strobe |
| wr_data | input | 16 | Value being written to the register file |
| instr | input | 16 | Current instruction word |
| pc_next | input | 16 | Incremented program counter of the instruction |
| flags | output | 3 | Current condition flags {N, Z, P} |
| br_taken | output | 1 | Branch is taken this cycle |
| br_target | output | 16 | Branch destination address |

## Verification
The flag path is driven with writes at the sign and zero boundaries: 16'h8000, 16'hFFFF, 16'h0000, 16'h0001 and 16'h7FFF. These values separate a sign-bit test from a magnitude test. Idle cycles between writes show whether the flags hold. Every mask value from 0 to 7 is applied against each of the three flag states. This exposes a mask bit wired to the wrong flag, and also a mask that is ANDed where it should be ORed. Non-branch opcodes with a full mask separate opcode decoding from condition matching. For the target adder, the extreme offsets +255 and -256 are combined with program counters near 0 and 16'hFFFF, so that a missing sign extension and missing wraparound each give a wrong address.

// File: rtl/ccr_pkg.sv
package ccr_pkg;
  localparam int NUM_FLAGS = 3;

  typedef enum logic [1:0] {
    FLAG_POS  = 2'd0,
    FLAG_ZERO = 2'd1,
    FLAG_NEG  = 2'd2
  } flag_idx_e;

  function automatic logic [NUM_FLAGS-1:0] cc_classify(input logic is_neg, input logic is_zero);
    logic [NUM_FLAGS-1:0] f;
    f = '0;
    if (is_neg)       f[FLAG_NEG]  = 1'b1;
    else if (is_zero) f[FLAG_ZERO] = 1'b1;
    else              f[FLAG_POS]  = 1'b1;
    return f;
  endfunction

  function automatic logic [NUM_FLAGS-1:0] cc_reset_value();
    logic [NUM_FLAGS-1:0] f;
    f = '0;
    f[FLAG_ZERO] = 1'b1;
    return f;
  endfunction
endpackage

// File: rtl/ccr_flag_reg.sv
module ccr_flag_reg
  import ccr_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  output logic [NUM_FLAGS-1:0] flags_q,
  output logic [NUM_FLAGS-1:0] flags_d
);
  logic val_neg;
  logic val_zero;

  assign val_neg  = wr_data[DATA_W-1];
  assign val_zero = (wr_data == '0);
  assign flags_d  = cc_classify(val_neg, val_zero);

  always_ff @(posedge clk) begin
    if (!rst_n)     flags_q <= cc_reset_value();
    else if (wr_en) flags_q <= flags_d;
  end
endmodule

// File: rtl/ccr_br_decode.sv
module ccr_br_decode
  import ccr_pkg::*;
#(
  parameter int INSTR_W = 16,
  parameter int OPC_W   = 4,
  parameter logic [OPC_W-1:0] OPC_BRANCH = '0,
  parameter int MASK_LSB = 9
) (
  input  logic [INSTR_W-1:0]   instr,
  input  logic [NUM_FLAGS-1:0] flags,
  output logic                 is_branch,
  output logic [NUM_FLAGS-1:0] cond_hit,
  output logic                 taken
);
  localparam int OPC_LSB = INSTR_W - OPC_W;

  logic [NUM_FLAGS-1:0] mask;

  assign is_branch = (instr[INSTR_W-1:OPC_LSB] == OPC_BRANCH);
  assign mask      = instr[MASK_LSB +: NUM_FLAGS];

  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_hit
    assign cond_hit[g] = mask[g] & flags[g];
  end

  assign taken = is_branch & (|cond_hit);
endmodule

// File: rtl/ccr_target_add.sv
module ccr_target_add #(
  parameter int ADDR_W = 16,
  parameter int OFFS_W = 9
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [OFFS_W-1:0] offset,
  output logic [ADDR_W-1:0] target
);
  localparam int EXT_W = ADDR_W - OFFS_W;

  function automatic logic [ADDR_W-1:0] sext_offset(input logic [OFFS_W-1:0] o);
    return {{EXT_W{o[OFFS_W-1]}}, o};
  endfunction

  logic [ADDR_W-1:0] offset_ext;

  assign offset_ext = sext_offset(offset);
  assign target     = base + offset_ext;
endmodule

// File: rtl/ccr_branch_unit.sv
module ccr_branch_unit
  import ccr_pkg::*;
#(
  parameter int DATA_W  = 16,
  parameter int INSTR_W = 16,
  parameter int ADDR_W  = 16,
  parameter int OPC_W   = 4,
  parameter int OFFS_W  = 9
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 wr_en,
  input  logic [DATA_W-1:0]    wr_data,
  input  logic [INSTR_W-1:0]   instr,
  input  logic [ADDR_W-1:0]    pc_next,
  output logic [NUM_FLAGS-1:0] flags,
  output logic                 br_taken,
  output logic [ADDR_W-1:0]    br_target
);
  localparam int MASK_LSB = OFFS_W;

  logic [NUM_FLAGS-1:0] flags_q;
  logic [NUM_FLAGS-1:0] flags_next;
  logic                 is_branch;
  logic [NUM_FLAGS-1:0] cond_hit;

  ccr_flag_reg #(.DATA_W(DATA_W)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_data (wr_data),
    .flags_q (flags_q),
    .flags_d (flags_next)
  );

  ccr_br_decode #(
    .INSTR_W    (INSTR_W),
    .OPC_W      (OPC_W),
    .OPC_BRANCH ('0),
    .MASK_LSB   (MASK_LSB)
  ) u_decode (
    .instr     (instr),
    .flags     (flags_q),
    .is_branch (is_branch),
    .cond_hit  (cond_hit),
    .taken     (br_taken)
  );

  ccr_target_add #(.ADDR_W(ADDR_W), .OFFS_W(OFFS_W)) u_target (
    .base   (pc_next),
    .offset (instr[OFFS_W-1:0]),
    .target (br_target)
  );

  assign flags = flags_q;
endmodule

// File: rtl/ccr_branch_unit_checker.sv
module ccr_branch_unit_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        wr_en,
  input logic [15:0] wr_data,
  input logic [15:0] instr,
  input logic [2:0]  flags,
  input logic [2:0]  flags_next,
  input logic        is_branch,
  input logic        br_taken
);
  a_r2_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags) == 1);

  a_r2_next_one_hot: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(flags_next) == 1);

  a_r3_neg_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data[15]) |=> (flags == 3'b100));

  a_r4_zero_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_data == 16'h0000) |=> (flags == 3'b010));

  a_r5_pos_write: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_data[15] && wr_data != 16'h0000) |=> (flags == 3'b001));

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(flags));

  a_r8_empty_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[11:9] == 3'b000) |-> !br_taken);

  a_r9_full_mask: assert property (@(posedge clk) disable iff (!rst_n)
    (is_branch && instr[11:9] == 3'b111) |-> br_taken);

  a_r10_other_opcode: assert property (@(posedge clk) disable iff (!rst_n)
    (instr[15:12] != 4'b0000) |-> !br_taken);
endmodule

bind ccr_branch_unit ccr_branch_unit_checker u_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .wr_en      (wr_en),
  .wr_data    (wr_data),
  .instr      (instr),
  .flags      (flags),
  .flags_next (flags_next),
  .is_branch  (is_branch),
  .br_taken   (br_taken)
);

// File: tb/test_ccr_branch_unit.sv
`timescale 1ns/1ps
module test_ccr_branch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] instr = '0;
  logic [15:0] pc_next = '0;
  logic [2:0]  flags;
  logic        br_taken;
  logic [15:0] br_target;

  int    n_tests = 0;
  int    n_fail  = 0;
  int    ref_flags = 2;
  string flag_tag = "R1";
  bit    done = 0;

  always #2.5 clk = ~clk;

  ccr_branch_unit i_ccr_branch_unit (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
    .instr(instr), .pc_next(pc_next), .flags(flags),
    .br_taken(br_taken), .br_target(br_target)
  );

  task automatic check(string tag, int actual, int expected);
    n_tests++;
    if (actual != expected) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, actual, expected);
    end
  endtask

  // One cycle: drive at the falling edge, compare before the rising edge, then advance the model.
  task automatic cycle(bit we, int wd, int ins, int pc);
    int mask, exp_taken, off, exp_tgt, ones;
    string ttag;
    @(negedge clk);
    wr_en = we; wr_data = wd[15:0]; instr = ins[15:0]; pc_next = pc[15:0];
    #1;
    check(flag_tag, int'(flags), ref_flags);
    ones = 0;
    for (int b = 0; b < 3; b++) if (flags[b]) ones++;
    check("R2", ones, 1);
    mask = (ins >> 9) & 7;
    if (((ins >> 12) & 15) != 0) begin exp_taken = 0; ttag = "R10"; end
    else begin
      exp_taken = ((mask & ref_flags) != 0) ? 1 : 0;
      ttag = (mask == 0) ? "R8" : (mask == 7) ? "R9" : "R7";
    end
    check(ttag, int'(br_taken), exp_taken);
    off = ins & 511;
    if (off >= 256) off = off - 512;
    exp_tgt = (pc + off) & 65535;
    check("R11", int'(br_target), exp_tgt);
    @(posedge clk);
    if (we) begin
      if ((wd & 16'h8000) != 0) begin ref_flags = 4; flag_tag = "R3"; end
      else if ((wd & 65535) == 0) begin ref_flags = 2; flag_tag = "R4"; end
      else begin ref_flags = 1; flag_tag = "R5"; end
    end else if (flag_tag != "R1") flag_tag = "R6";
  endtask

  task automatic sweep_masks(int pc);
    for (int m = 0; m < 8; m++) cycle(0, 0, m << 9, pc);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1: reset state, branches resolved against Z
    sweep_masks(16'h3000);
    cycle(0, 0, 16'h0000, 16'h1234);      // R8 literal no-op word
    cycle(0, 0, 16'h0E00, 16'h1234);      // R9 literal always word
    // R3: negative writes
    cycle(1, 16'h8000, 16'h0000, 16'h0100);
    sweep_masks(16'h0100);
    cycle(1, 16'hFFFF, 16'h0800, 16'h0200);
    cycle(0, 0, 16'h0800, 16'h0200);      // R6 hold
    // R5: positive writes
    cycle(1, 16'h0001, 16'h0000, 16'h0300);
    sweep_masks(16'h0300);
    cycle(1, 16'h7FFF, 16'h0200, 16'h0400);
    cycle(0, 0, 16'h0200, 16'h0400);
    // R4: zero write after positive
    cycle(1, 16'h0000, 16'h0400, 16'h0500);
    sweep_masks(16'h0500);
    // R10: other opcodes with a full mask
    cycle(0, 0, 16'h1E00, 16'h0600);
    cycle(0, 0, 16'hFE00, 16'h0600);
    cycle(0, 0, 16'h8FFF, 16'h0600);
    // R11: offset extremes and wraparound
    cycle(0, 0, 16'h0EFF, 16'h1000);      // +255
    cycle(0, 0, 16'h0F00, 16'h1000);      // -256
    cycle(0, 0, 16'h0E01, 16'hFFFF);      // wraps to 0
    cycle(0, 0, 16'h0FFF, 16'h0000);      // wraps to FFFF
    cycle(0, 0, 16'h0F00, 16'h00FF);
    // R6: write strobe low with changing data
    cycle(1, 16'h8001, 16'h0000, 0);
    cycle(0, 16'h0000, 16'h0000, 0);
    cycle(0, 16'h0005, 16'h0800, 0);
    cycle(0, 16'h0005, 16'h0800, 0);
    // back-to-back writes of each class
    cycle(1, 16'h0000, 16'h0400, 0);
    cycle(1, 16'h0042, 16'h0200, 0);
    cycle(1, 16'hC000, 16'h0A00, 0);
    cycle(0, 0, 16'h0600, 0);
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1;
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule